// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the array address for a burst access to a synchronous memory. When an address-strobe cycle is accepted, it registers the full external address. It then walks the two least significant bits through a four-beat group each time the advance input is asserted. The upper address bits stay as loaded for the whole burst.

Two active-low strobes can start a burst. One belongs to a processor and the other to a cache controller, and each is qualified differently by the chip enables. A mode input selects the beat order. The order is either a linear count that wraps inside the aligned group of four, or an order formed by XOR with the beat number.

The memory array, the write datapath and output enable handling lie outside this block. The output address comes straight from the internal registers and the present mode level, so a new address is visible in the cycle after the clock edge that produced it.

Top module: `sba_burst_addr`

## Requirements
- R1: With `proc_strb_n` low and all three enables active (`ce_n` low, `ce_hi` high, `ce2_n` low), the next clock edge loads `ext_addr`. After that edge `cur_addr` equals it.
- R2: With `ctrl_strb_n` low and all three enables active, and the processor strobe inactive or ignored, the next clock edge loads `ext_addr` into `cur_addr`.
- R3: The processor strobe is ignored while `ce_n` is high. The cycle is then decoded from `ctrl_strb_n` and `adv_n` alone.
- R4: A strobe that is not ignored, seen while any of the three enables is inactive, deselects the cycle. No load occurs, and `cur_addr` holds even when `adv_n` is low.
- R5: When both strobes are low and all enables are active, the processor strobe takes priority and the start address is loaded.
- R6: With `mode` = 0, the low two bits on beat n equal (start + n) mod 4. They wrap inside the four-beat group and never carry into bit 2.
- R7: With `mode` = 1, the low two bits on beat n equal start XOR n, for n = 0..3. The mode level applies combinationally to the present beat.
- R8: With no strobe in effect and `adv_n` low, the sequencer moves to the next beat. After the fourth beat it keeps wrapping through the same four addresses, and no end flag exists.
- R9: With no strobe in effect and `adv_n` high, the burst is suspended and `cur_addr` holds.
- R10: Bits above the two beat bits change only on a load.
- R11: While `rst_n` is low, and after it is released, `cur_addr` is zero until the first load or advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | ADDR_W | External start address |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Tertiary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode | input | 1 | Beat order: 0 linear, 1 interleaved |
| cur_addr | output | ADDR_W | Current array address |

## Verification
The assertions check several properties on every cycle. Each qualified strobe load shows the external address one cycle later, and a deselected or suspended cycle leaves the address unchanged. The upper bits never move without a load, and a linear advance adds exactly one modulo four to the low bits. The full interleaved orders for different start beats can only be shown by the bench's scenarios, since each step there depends on the beat number. The same holds for wrap-around past the fourth beat, a mode change in the middle of a burst, and strobe priority.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [1:0] {
    SBA_HOLD  = 2'd0,
    SBA_LOAD  = 2'd1,
    SBA_STEP  = 2'd2,
    SBA_DESEL = 2'd3
  } sba_op_e;

endpackage

// File: rtl/sba_strobe_decode.sv
module sba_strobe_decode
  import sba_pkg::*;
(
  input  logic    proc_strb_n,
  input  logic    ctrl_strb_n,
  input  logic    ce_n,
  input  logic    ce_hi,
  input  logic    ce2_n,
  input  logic    adv_n,
  output sba_op_e op
);

  logic chip_en;
  logic proc_live;
  logic ctrl_live;

  // processor strobe only counts while the primary enable is active
  assign chip_en   = !ce_n && ce_hi && !ce2_n;
  assign proc_live = !proc_strb_n && !ce_n;
  assign ctrl_live = !ctrl_strb_n;

  always_comb begin
    op = SBA_HOLD;
    if (proc_live) begin
      op = chip_en ? SBA_LOAD : SBA_DESEL;
    end else if (ctrl_live) begin
      op = chip_en ? SBA_LOAD : SBA_DESEL;
    end else if (!adv_n) begin
      op = SBA_STEP;
    end else begin
      op = SBA_HOLD;
    end
  end

endmodule

// File: rtl/sba_beat_counter.sv
module sba_beat_counter
  import sba_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sba_op_e                    op,
  input  logic [ADDR_W-1:0]          ext_addr,
  output logic [ADDR_W-BEAT_W-1:0]   upper_q,
  output logic [BEAT_W-1:0]          base_q,
  output logic [BEAT_W-1:0]          cnt_q
);

  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upper_d;
  logic [BEAT_W-1:0] base_d;
  logic [BEAT_W-1:0] cnt_d;
  logic              addr_en;
  logic              cnt_en;

  assign addr_en = (op == SBA_LOAD);
  assign cnt_en  = (op == SBA_LOAD) || (op == SBA_STEP);

  always_comb begin
    upper_d = upper_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    unique case (op)
      SBA_LOAD: begin
        upper_d = ext_addr[ADDR_W-1:BEAT_W];
        base_d  = ext_addr[BEAT_W-1:0];
        cnt_d   = '0;
      end
      SBA_STEP: cnt_d = cnt_q + BEAT_W'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
    end else if (addr_en) begin
      upper_q <= upper_d;
      base_q  <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sba_order_map.sv
module sba_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base,
  input  logic [BEAT_W-1:0] cnt,
  input  logic              mode,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  // linear: modulo add inside the aligned group
  assign lin_low = base + cnt;

  // interleaved: bitwise flip of the start beat by the beat number
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = base[b] ^ cnt[b];
  end

  assign low = mode ? ilv_low : lin_low;

endmodule

// File: rtl/sba_burst_addr.sv
module sba_burst_addr
  import sba_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              ce_n,
  input  logic              ce_hi,
  input  logic              ce2_n,
  input  logic              adv_n,
  input  logic              mode,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int UP_W = ADDR_W - BEAT_W;

  sba_op_e           op;
  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] low;

  sba_strobe_decode u_dec (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .ce_n        (ce_n),
    .ce_hi       (ce_hi),
    .ce2_n       (ce2_n),
    .adv_n       (adv_n),
    .op          (op)
  );

  sba_beat_counter #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ext_addr (ext_addr),
    .upper_q  (upper_q),
    .base_q   (base_q),
    .cnt_q    (cnt_q)
  );

  sba_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base (base_q),
    .cnt  (cnt_q),
    .mode (mode),
    .low  (low)
  );

  assign cur_addr = {upper_q, low};

endmodule

// File: rtl/sba_burst_addr_chk.sv
module sba_burst_addr_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              ce_n,
  input logic              ce_hi,
  input logic              ce2_n,
  input logic              adv_n,
  input logic              mode,
  input logic [ADDR_W-1:0] cur_addr
);

  logic en_all;
  logic proc_eff;
  logic no_strobe;
  assign en_all    = !ce_n && ce_hi && !ce2_n;
  assign proc_eff  = !proc_strb_n && !ce_n;
  assign no_strobe = !proc_eff && ctrl_strb_n;

  // R1
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_eff && en_all) |=> (cur_addr == $past(ext_addr)));

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_eff && !ctrl_strb_n && en_all) |=> (cur_addr == $past(ext_addr)));

  // R4
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_eff || !ctrl_strb_n) && !en_all) |=>
      ((mode != $past(mode)) || $stable(cur_addr)));

  // R9
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && adv_n) |=> ((mode != $past(mode)) || $stable(cur_addr)));

  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en_all && (proc_eff || !ctrl_strb_n))) |=>
      $stable(cur_addr[ADDR_W-1:BEAT_W]));

  // R6
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !adv_n && !mode) |=>
      (mode || (cur_addr[BEAT_W-1:0] == BEAT_W'($past(cur_addr[BEAT_W-1:0]) + 1'b1))));

endmodule

bind sba_burst_addr sba_burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_addr    (ext_addr),
  .proc_strb_n (proc_strb_n),
  .ctrl_strb_n (ctrl_strb_n),
  .ce_n        (ce_n),
  .ce_hi       (ce_hi),
  .ce2_n       (ce2_n),
  .adv_n       (adv_n),
  .mode        (mode),
  .cur_addr    (cur_addr)
);

// File: tb/sba_burst_addr_test.sv
module sba_burst_addr_test;

  localparam int AW = 17;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          proc_strb_n, ctrl_strb_n, ce_n, ce_hi, ce2_n, adv_n, mode;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  // reference state derived from the requirements
  logic [AW-3:0] m_up;
  logic [1:0]    m_base;
  logic [1:0]    m_cnt;

  sba_burst_addr uut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .ce_n(ce_n), .ce_hi(ce_hi), .ce2_n(ce2_n),
    .adv_n(adv_n), .mode(mode), .cur_addr(cur_addr)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cur_addr=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_out(input logic md);
    logic [1:0] lo;
    lo = md ? (m_base ^ m_cnt) : 2'(m_base + m_cnt);
    return {m_up, lo};
  endfunction

  // drives one cycle, updates the model and queues the expected address
  task automatic step(input logic [AW-1:0] a, input logic p_n, input logic c_n,
                      input logic e_n, input logic e_hi, input logic e2_n,
                      input logic av_n, input logic md, input string tag);
    logic en;
    ext_addr = a; proc_strb_n = p_n; ctrl_strb_n = c_n;
    ce_n = e_n; ce_hi = e_hi; ce2_n = e2_n; adv_n = av_n; mode = md;
    en = !e_n && e_hi && !e2_n;
    if ((!p_n && !e_n) || !c_n) begin
      if (en) begin m_up = a[AW-1:2]; m_base = a[1:0]; m_cnt = 2'd0; end
    end else if (!av_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    @(posedge clk);
    exp_q.push_back(model_out(md));
    tag_q.push_back(tag);
    #2;
  endtask

  // monitor: pops and compares each result after it settles
  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (exp_q.size() > 0) check(cur_addr, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic idle(input logic av_n, input logic md, input string tag);
    step('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, av_n, md, tag);
  endtask

  initial begin
    ext_addr = '0; proc_strb_n = 1; ctrl_strb_n = 1; ce_n = 0; ce_hi = 1; ce2_n = 0;
    adv_n = 1; mode = 0; rst_n = 0;
    m_up = '0; m_base = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #2;
    check(cur_addr, '0, "R11 in reset");
    rst_n = 1;
    @(posedge clk); #2;
    check(cur_addr, '0, "R11 after release");

    // R1 linear burst from low beat 1, with wrap and no carry (R6, R8)
    step(17'h0A5C5, 0, 1, 0, 1, 0, 1, 0, "R1 proc load");
    for (int i = 0; i < 6; i++) idle(0, 0, "R6 R8 linear advance wrap");
    // R9 suspend
    idle(1, 0, "R9 suspend");
    idle(1, 0, "R9 suspend again");
    // R7 interleaved from beat 2 and from beat 3
    step(17'h1F00E, 1, 0, 0, 1, 0, 1, 1, "R2 ctrl load");
    for (int i = 0; i < 5; i++) idle(0, 1, "R7 interleaved advance");
    step(17'h00133, 0, 1, 0, 1, 0, 0, 1, "R1 proc load beat3");
    for (int i = 0; i < 4; i++) idle(0, 1, "R7 R8 interleaved from 3");
    // mode change mid-burst applies to present beat
    idle(1, 0, "R7 mode switch to linear");
    idle(0, 0, "R6 linear after switch");
    // R3 proc ignored with ce_n high: advance instead of load
    step(17'h15555, 0, 1, 1, 1, 0, 0, 0, "R3 proc ignored advances");
    step(17'h15555, 0, 1, 1, 1, 0, 1, 0, "R3 proc ignored holds");
    // R4 deselects
    step(17'h0AAAA, 1, 0, 1, 1, 0, 0, 0, "R4 ctrl with ce_n high");
    step(17'h0AAAA, 1, 0, 0, 0, 0, 0, 0, "R4 ctrl with ce_hi low");
    step(17'h0AAAA, 0, 1, 0, 1, 1, 0, 0, "R4 proc with ce2_n high");
    idle(1, 0, "R10 upper unchanged");
    // R5 both strobes
    step(17'h10002, 0, 0, 0, 1, 0, 1, 0, "R5 both strobes load");
    idle(0, 0, "R5 R6 first advance");
    // R2 ctrl loads while proc ignored
    step(17'h07FFF, 0, 0, 1, 1, 0, 1, 1, "R2 ctrl load with proc ignored");
    // note: ce_n high disables, so no load; checks R4 path with proc ignored
    step(17'h07FFF, 1, 0, 0, 1, 0, 1, 1, "R2 ctrl load enabled");
    idle(0, 1, "R7 R10 interleaved from 3 upper kept");
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule